// File: doc/BRIEF.md
# Split-Bank Display Window Address Mapper

This block turns a CPU access that falls inside a 64 KB display window into a full 20-bit video-memory address. It holds a bank for writes (also used for all accesses in the normal mode) and a separate bank for reads. When split mode is on, reads take the read bank and writes take the write bank. The bank counts in 4 KB steps in packed-pixel modes and in 1 KB steps in 16-colour planar modes. One extra high bank bit comes from bit 5 of a separate miscellaneous output register.

The bank and control registers sit behind an indexed port: a one-byte index register is selected with `reg_sel` low and a one-byte data register with `reg_sel` high. An unlock register at index 0x06 must be written with a magic code before the bank registers accept writes or show their contents. The address output is combinational from the current offset, direction, pixel mode and registered bank state, so a register write affects the mapping from the clock edge that stores it.

Top module: `vwb_top`

## Requirements
- R1: A data write of 0xEA while the index register holds 0x06 enables the extensions from the next clock edge.
- R2: A data write of 0xAE to index 0x06 disables the extensions, and any other value written there leaves the enable state unchanged.
- R3: Reading data at index 0x06 returns 0x01 while the extensions are enabled and 0x00 while they are disabled.
- R4: While the extensions are disabled, data writes to indices 0xE0, 0xE8 and 0xE9 are ignored and data reads of them return 0x00.
- R5: While the extensions are enabled, indices 0xE0 (mode control), 0xE8 (write bank) and 0xE9 (read bank) read back the last value written; a read with `reg_sel` low returns the index register; any other index reads 0x00.
- R6: When bit 7 of index 0xE0 is clear, both reads and writes use the write bank at index 0xE8.
- R7: When bit 7 of index 0xE0 is set, reads (`cpu_we`=0) use the read bank at index 0xE9 and writes (`cpu_we`=1) use the write bank.
- R8: The address is the 9-bit bank value shifted left by 12 when `planar_mode` is 0 or by 10 when it is 1, plus `cpu_off`, kept to its low 20 bits.
- R9: The miscellaneous output register is written through `misc_wr` and reads back all 8 bits on `misc_rdata`; its bit 5 forms bit 8 of the bank value, above the 8-bit bank register.
- R10: After reset the extensions are disabled, every register is zero and `mem_addr` equals `cpu_off`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the index register, 1 the data register |
| reg_wr | input | 1 | Write strobe for the indexed port |
| reg_wdata | input | 8 | Write data for the indexed port |
| reg_rdata | output | 8 | Read data of the selected register |
| misc_wr | input | 1 | Write strobe for the miscellaneous output register |
| misc_wdata | input | 8 | Write data for the miscellaneous output register |
| misc_rdata | output | 8 | Readback of the miscellaneous output register |
| cpu_off | input | 16 | Byte offset of the CPU access within the window |
| cpu_we | input | 1 | 1 for a CPU write, 0 for a CPU read |
| planar_mode | input | 1 | 1 selects 1 KB bank steps, 0 selects 4 KB steps |
| mem_addr | output | 20 | Mapped video-memory address |

## Verification
A wrong enable flag shows at once on the index 0x06 readback and, one cycle after a bank write that should have been ignored or kept, on `mem_addr`. A bank register holding a bad value or a split flag stuck in the wrong state moves `mem_addr` in the same cycle the CPU offset is applied, since the address path has no register. A mode bit routed the wrong way shows as a fixed shift of the upper address bits for every access that uses a nonzero bank.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  localparam logic [7:0] IDX_EXT   = 8'h06;
  localparam logic [7:0] IDX_CTRL  = 8'hE0;
  localparam logic [7:0] IDX_WBANK = 8'hE8;
  localparam logic [7:0] IDX_RBANK = 8'hE9;
  localparam logic [7:0] CODE_ON   = 8'hEA;
  localparam logic [7:0] CODE_OFF  = 8'hAE;
  localparam int         SPLIT_BIT = 7;
  localparam int         HIBANK_BIT = 5;
endpackage

// File: rtl/vwb_regs.sv
module vwb_regs
  import vwb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          misc_wr,
  input  logic [DW-1:0] misc_wdata,
  output logic [DW-1:0] misc_q,
  output logic [DW-1:0] idx_q,
  output logic          ext_en_q,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] wbank_q,
  output logic [DW-1:0] rbank_q
);
  logic          data_wr, idx_wr, ext_hit;
  logic          ext_en_d;
  logic [DW-1:0] idx_d, ctrl_d, wbank_d, rbank_d, misc_d;

  assign data_wr = reg_wr & reg_sel;
  assign idx_wr  = reg_wr & ~reg_sel;
  assign ext_hit = data_wr & (idx_q == IDX_EXT);

  always_comb begin
    idx_d    = idx_wr  ? reg_wdata  : idx_q;
    misc_d   = misc_wr ? misc_wdata : misc_q;
    ext_en_d = ext_en_q;
    if (ext_hit && reg_wdata == CODE_ON)  ext_en_d = 1'b1;
    if (ext_hit && reg_wdata == CODE_OFF) ext_en_d = 1'b0;
    ctrl_d  = ctrl_q;
    wbank_d = wbank_q;
    rbank_d = rbank_q;
    if (data_wr && ext_en_q) begin
      unique case (idx_q)
        IDX_CTRL:  ctrl_d  = reg_wdata;
        IDX_WBANK: wbank_d = reg_wdata;
        IDX_RBANK: rbank_d = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      misc_q   <= '0;
      ext_en_q <= 1'b0;
      ctrl_q   <= '0;
      wbank_q  <= '0;
      rbank_q  <= '0;
    end else begin
      idx_q    <= idx_d;
      misc_q   <= misc_d;
      ext_en_q <= ext_en_d;
      ctrl_q   <= ctrl_d;
      wbank_q  <= wbank_d;
      rbank_q  <= rbank_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_sel) begin
      reg_rdata = idx_q;
    end else begin
      unique case (idx_q)
        IDX_EXT:   reg_rdata = {{(DW-1){1'b0}}, ext_en_q};
        IDX_CTRL:  reg_rdata = ext_en_q ? ctrl_q  : '0;
        IDX_WBANK: reg_rdata = ext_en_q ? wbank_q : '0;
        IDX_RBANK: reg_rdata = ext_en_q ? rbank_q : '0;
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vwb_addr.sv
module vwb_addr #(
  parameter int AW = 20,
  parameter int OW = 16,
  parameter int BW = 8,
  parameter int SHIFT_PACKED = 12,
  parameter int SHIFT_PLANAR = 10
) (
  input  logic [BW-1:0] wbank,
  input  logic [BW-1:0] rbank,
  input  logic          bank_hi,
  input  logic          split_en,
  input  logic          cpu_we,
  input  logic          planar_mode,
  input  logic [OW-1:0] cpu_off,
  output logic [AW-1:0] mem_addr
);
  localparam int FBW = BW + 1;

  logic          use_rbank;
  logic [FBW-1:0] bank_full;
  logic [AW-1:0]  bank_wide, base;

  assign use_rbank = split_en & ~cpu_we;
  assign bank_full = {bank_hi, (use_rbank ? rbank : wbank)};
  assign bank_wide = AW'(bank_full);
  assign base      = planar_mode ? (bank_wide << SHIFT_PLANAR)
                                 : (bank_wide << SHIFT_PACKED);
  assign mem_addr  = base + AW'(cpu_off);
endmodule

// File: rtl/vwb_top.sv
module vwb_top
  import vwb_pkg::*;
#(
  parameter int AW = 20,
  parameter int OW = 16,
  parameter int DW = 8,
  parameter int SHIFT_PACKED = 12,
  parameter int SHIFT_PLANAR = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          misc_wr,
  input  logic [DW-1:0] misc_wdata,
  output logic [DW-1:0] misc_rdata,
  input  logic [OW-1:0] cpu_off,
  input  logic          cpu_we,
  input  logic          planar_mode,
  output logic [AW-1:0] mem_addr
);
  logic [DW-1:0] misc_q, idx_q, ctrl_q, wbank_q, rbank_q;
  logic          ext_en_q;

  vwb_regs #(.DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .misc_wr    (misc_wr),
    .misc_wdata (misc_wdata),
    .misc_q     (misc_q),
    .idx_q      (idx_q),
    .ext_en_q   (ext_en_q),
    .ctrl_q     (ctrl_q),
    .wbank_q    (wbank_q),
    .rbank_q    (rbank_q)
  );

  vwb_addr #(
    .AW(AW), .OW(OW), .BW(DW),
    .SHIFT_PACKED(SHIFT_PACKED), .SHIFT_PLANAR(SHIFT_PLANAR)
  ) u_addr (
    .wbank       (wbank_q),
    .rbank       (rbank_q),
    .bank_hi     (misc_q[HIBANK_BIT]),
    .split_en    (ctrl_q[SPLIT_BIT]),
    .cpu_we      (cpu_we),
    .planar_mode (planar_mode),
    .cpu_off     (cpu_off),
    .mem_addr    (mem_addr)
  );

  assign misc_rdata = misc_q;
endmodule

// File: rtl/vwb_chk.sv
module vwb_chk #(
  parameter int AW = 20,
  parameter int OW = 16,
  parameter int DW = 8,
  parameter int SHIFT_PACKED = 12,
  parameter int SHIFT_PLANAR = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_sel,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] idx_q,
  input logic          ext_en_q,
  input logic [DW-1:0] wbank_q,
  input logic [OW-1:0] cpu_off,
  input logic          planar_mode,
  input logic [AW-1:0] mem_addr
);
  assert_unlock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && idx_q == 8'h06 && reg_wdata == 8'hEA) |=> ext_en_q);

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && idx_q == 8'h06 && reg_wdata == 8'hAE) |=> !ext_en_q);

  assert_locked_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !ext_en_q && idx_q == 8'hE8) |=> $stable(wbank_q));

  assert_locked_rd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !ext_en_q && (idx_q == 8'hE0 || idx_q == 8'hE8 || idx_q == 8'hE9))
      |-> reg_rdata == '0);

  assert_low_bits_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[SHIFT_PLANAR-1:0] == cpu_off[SHIFT_PLANAR-1:0]);

  assert_packed_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !planar_mode |-> mem_addr[SHIFT_PACKED-1:0] == cpu_off[SHIFT_PACKED-1:0]);
endmodule

bind vwb_top vwb_chk #(
  .AW(AW), .OW(OW), .DW(DW),
  .SHIFT_PACKED(SHIFT_PACKED), .SHIFT_PLANAR(SHIFT_PLANAR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_sel     (reg_sel),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .idx_q       (idx_q),
  .ext_en_q    (ext_en_q),
  .wbank_q     (wbank_q),
  .cpu_off     (cpu_off),
  .planar_mode (planar_mode),
  .mem_addr    (mem_addr)
);

// File: tb/sim_vwb_top.sv
module sim_vwb_top;
  localparam int PERIOD = 10;

  logic        clk, rst_n, reg_sel, reg_wr, misc_wr, cpu_we, planar_mode;
  logic [7:0]  reg_wdata, reg_rdata, misc_wdata, misc_rdata;
  logic [15:0] cpu_off;
  logic [19:0] mem_addr;

  int total = 0;
  int bad = 0;

  logic       m_en;
  logic [7:0] m_idx, m_ctrl, m_wb, m_rb, m_misc;

  vwb_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .misc_wr(misc_wr),
    .misc_wdata(misc_wdata), .misc_rdata(misc_rdata), .cpu_off(cpu_off),
    .cpu_we(cpu_we), .planar_mode(planar_mode), .mem_addr(mem_addr)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(input logic [15:0] off, input logic we,
                                           input logic pl);
    logic [8:0]  bank;
    logic [31:0] a;
    bank = {m_misc[5], ((m_ctrl[7] && !we) ? m_rb : m_wb)};
    a = (pl ? (32'(bank) << 10) : (32'(bank) << 12)) + 32'(off);
    return a[19:0];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] idx);
    case (idx)
      8'h06:               return {7'b0, m_en};
      8'hE0:               return m_en ? m_ctrl : 8'h00;
      8'hE8:               return m_en ? m_wb   : 8'h00;
      8'hE9:               return m_en ? m_rb   : 8'h00;
      default:             return 8'h00;
    endcase
  endfunction

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic idx_write(input logic [7:0] v);
    reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
    m_idx = v;
  endtask

  task automatic dat_write(input logic [7:0] v);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v;
    step();
    reg_wr = 1'b0;
    if (m_idx == 8'h06 && v == 8'hEA) m_en = 1'b1;
    else if (m_idx == 8'h06 && v == 8'hAE) m_en = 1'b0;
    else if (m_en && m_idx == 8'hE0) m_ctrl = v;
    else if (m_en && m_idx == 8'hE8) m_wb = v;
    else if (m_en && m_idx == 8'hE9) m_rb = v;
  endtask

  task automatic misc_write(input logic [7:0] v);
    misc_wr = 1'b1; misc_wdata = v;
    step();
    misc_wr = 1'b0;
    m_misc = v;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
    idx_write(idx);
    dat_write(v);
  endtask

  task automatic read_at(input string req, input logic [7:0] idx);
    idx_write(idx);
    reg_sel = 1'b1;
    #1;
    chk(req, 32'(reg_rdata), 32'(exp_rd(idx)));
  endtask

  task automatic addr_at(input string req, input logic [15:0] off, input logic we,
                         input logic pl, input logic [19:0] lit);
    cpu_off = off; cpu_we = we; planar_mode = pl;
    #1;
    chk(req, 32'(mem_addr), 32'(lit));
    chk(req, 32'(mem_addr), 32'(exp_addr(off, we, pl)));
  endtask

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    misc_wr = 1'b0; misc_wdata = '0; cpu_off = 16'h1234; cpu_we = 1'b0;
    planar_mode = 1'b0;
    m_en = 1'b0; m_idx = '0; m_ctrl = '0; m_wb = '0; m_rb = '0; m_misc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 addr", 32'(mem_addr), 32'h01234);
    chk("R10 misc", 32'(misc_rdata), 32'h0);
    chk("R10 index", 32'(reg_rdata), 32'h0);
    read_at("R10 R3 ext off", 8'h06);

    // R4 locked write ignored, read zero
    reg_write(8'hE8, 8'h55);
    read_at("R4 locked read", 8'hE8);
    addr_at("R4 locked bank unchanged", 16'h0010, 1'b1, 1'b0, 20'h00010);

    // R1 unlock, R3 readback
    reg_write(8'h06, 8'hEA);
    read_at("R1 R3 ext on", 8'h06);
    read_at("R4 ignored write stays zero", 8'hE8);
    // R2 other code keeps enable
    reg_write(8'h06, 8'h12);
    read_at("R2 other code", 8'h06);

    // R6 non-split uses write bank for both directions
    reg_write(8'hE8, 8'h03);
    reg_write(8'hE9, 8'h05);
    read_at("R5 wbank", 8'hE8);
    read_at("R5 rbank", 8'hE9);
    addr_at("R6 read wbank", 16'h0123, 1'b0, 1'b0, 20'h03123);
    addr_at("R6 write wbank", 16'h0123, 1'b1, 1'b0, 20'h03123);

    // R7 split
    reg_write(8'hE0, 8'h80);
    read_at("R5 ctrl", 8'hE0);
    addr_at("R7 read rbank", 16'h0123, 1'b0, 1'b0, 20'h05123);
    addr_at("R7 write wbank", 16'h0123, 1'b1, 1'b0, 20'h03123);
    // R8 planar granularity
    addr_at("R8 planar", 16'h0123, 1'b1, 1'b1, 20'h00D23);
    // R9 high bank bit
    misc_write(8'h20);
    chk("R9 misc readback", 32'(misc_rdata), 32'h20);
    addr_at("R9 planar hi bit", 16'h0123, 1'b0, 1'b1, 20'h41523);
    addr_at("R9 packed hi bit truncated", 16'h0123, 1'b0, 1'b0, 20'h05123);
    // R8 truncation at the top
    reg_write(8'hE8, 8'hFF);
    addr_at("R8 wrap", 16'hFFFF, 1'b1, 1'b0, 20'h0EFFF);

    // R2 lock again, R4 writes dropped
    reg_write(8'h06, 8'hAE);
    read_at("R2 ext off", 8'h06);
    reg_write(8'hE9, 8'h77);
    read_at("R4 locked ctrl read", 8'hE0);
    addr_at("R4 locked rbank kept", 16'h0000, 1'b0, 1'b0, 20'h05000);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int op;
      logic [7:0] v, ix;
      logic [15:0] off;
      logic we, pl;
      op = int'($urandom_range(0, 5));
      v  = 8'($urandom);
      case (int'($urandom_range(0, 4)))
        0: ix = 8'h06;
        1: ix = 8'hE0;
        2: ix = 8'hE8;
        3: ix = 8'hE9;
        default: ix = 8'($urandom);
      endcase
      case (op)
        0: reg_write(8'h06, ($urandom_range(0, 1) == 0) ? 8'hEA : 8'hAE);
        1: reg_write(ix, v);
        2: misc_write(v);
        3: idx_write(ix);
        default: reg_write(ix, v);
      endcase
      reg_sel = 1'b0;
      #1;
      chk("R5 index readback", 32'(reg_rdata), 32'(m_idx));
      reg_sel = 1'b1;
      #1;
      chk("R3 R4 R5 data readback", 32'(reg_rdata), 32'(exp_rd(m_idx)));
      chk("R9 misc", 32'(misc_rdata), 32'(m_misc));
      off = 16'($urandom); we = 1'($urandom); pl = 1'($urandom);
      cpu_off = off; cpu_we = we; planar_mode = pl;
      #1;
      chk("R6 R7 R8 address", 32'(mem_addr), 32'(exp_addr(off, we, pl)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule